// File: doc/BRIEF.md
# Four-Channel DMA Parameter Registers

This block holds the programmed state of four DMA channels and lets the CPU load and inspect that state over an 8-bit slave port. Each channel keeps a 16-bit memory address and a 16-bit count word. The count word packs a 14-bit value of N−1 for an N-byte block with a 2-bit transfer type above it: 00 verify, 01 write, 10 read. A single mode byte enables channels and arms an auto-reload. A status byte reports per-channel terminal count and an update flag.

A transfer sequencer outside the block reports each finished byte with a one-cycle `byte_done` pulse and names the channel on `act_ch`. The block advances that channel's address and count. It raises `tc_out` on the channel's last byte and `mark_out` on every 128th byte. When auto-reload is armed, it refills channel 2 from channel 3 once channel 2 finishes its block. The sequencer reads the active channel's address and transfer type from `cur_addr` and `cur_op`.

Top module: `dma_chan_regs`

## Requirements
- R1: Register codes 0–7 select channel code/2. An even code selects the address register and an odd code selects the count register. Both are accessed as two bytes, low byte first. An internal byte pointer toggles on every write or read to codes 0–7. A write cycle is any clock edge with `wr_n` low, and a read cycle is any edge with `rd_n` low.
- R2: A write to code 8 loads the mode byte: bits 3:0 drive `ch_en`, and bit 7 drives `auto_ld`. The same write returns the byte pointer to the low byte and clears the update flag.
- R3: Writes to codes 9–15 change nothing and leave the byte pointer unchanged. Reads of codes 9–15 return 0, and `dout` is 0 whenever `rd_n` is high.
- R4: On `byte_done`, channel `act_ch` increments its address by one. It also decrements the low 14 bits of its count modulo 2^14 and keeps bits 15:14 unchanged. `cur_addr` and `cur_op` show channel `act_ch`'s address and count bits 15:14.
- R5: `tc_out` is high in a `byte_done` cycle whose channel has a count of zero in its low 14 bits. That cycle also sets status bit `act_ch`, where status bits 3:0 hold the TC flags of channels 0–3.
- R6: Reading code 8 returns {3'b0, update flag, TC[3:0]} and clears all four TC bits after that cycle. A TC set in the same cycle as the read stays set.
- R7: `mark_out` is high in the `byte_done` cycle that completes the 128th, 256th, and later byte of a channel. Bytes are counted from the last write of that channel's count register or from its last reload.
- R8: When `auto_ld` is 1, a terminal `byte_done` on channel 2 copies channel 3's address and count into channel 2 instead of stepping them, and sets the update flag (status bit 4).
- R9: A status read does not clear the update flag. The next `byte_done` on channel 2 clears it, unless that byte reloads again, and so does a mode write.
- R10: If a CPU write and a `byte_done` hit the same register in one cycle, the CPU byte wins and the other byte keeps its old value. The channel's other register still steps.
- R11: After reset all registers, flags and the byte pointer are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 4 | Register code for CPU access |
| wr_n | input | 1 | Active-low write strobe |
| rd_n | input | 1 | Active-low read strobe |
| din | input | 8 | CPU write data |
| dout | output | 8 | CPU read data, 0 when not reading |
| byte_done | input | 1 | One byte finished on channel `act_ch` |
| act_ch | input | 2 | Channel being served |
| cur_addr | output | 16 | Address of channel `act_ch` |
| cur_op | output | 2 | Transfer type of channel `act_ch` |
| ch_en | output | 4 | Channel enables from the mode byte |
| auto_ld | output | 1 | Channel 3 to 2 reload armed |
| tc_out | output | 1 | Last byte of the block in this cycle |
| mark_out | output | 1 | 128-byte boundary in this cycle |

## Verification
Two clashes can land in one clock edge. A status read can clear the TC bits while a terminal byte sets one. A CPU write can load an address register while a finished byte steps it. The bench forces each clash by asserting `rd_n` at code 8, or `wr_n` at code 0, in the same cycle as a `byte_done` on channel 0. For the read clash it then checks that the read returned the old status and that a following status read shows the new TC bit. For the write clash it checks that the address carries the written byte rather than an increment, and that the count stepped anyway.

// File: rtl/dma_chan_regs.sv
module dma_chan_regs (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [3:0]  reg_addr,
  input  logic        wr_n,
  input  logic        rd_n,
  input  logic [7:0]  din,
  output logic [7:0]  dout,
  input  logic        byte_done,
  input  logic [1:0]  act_ch,
  output logic [15:0] cur_addr,
  output logic [1:0]  cur_op,
  output logic [3:0]  ch_en,
  output logic        auto_ld,
  output logic        tc_out,
  output logic        mark_out
);
  localparam int NCH = 4;
  localparam int CW  = 14;
  localparam int TW  = 7;

  logic [15:0]   addr_q  [NCH];
  logic [15:0]   cnt_q   [NCH];
  logic [TW-1:0] tally_q [NCH];
  logic [3:0]    tc_q, en_q;
  logic          auto_q, upd_q, ff_q;

  wire       is_ch    = ~reg_addr[3];
  wire       is_mode  = reg_addr == 4'd8;
  wire [1:0] sel      = reg_addr[2:1];
  wire       wr_ch    = ~wr_n & is_ch;
  wire       rd_ch    = ~rd_n & is_ch;
  wire       mode_wr  = ~wr_n & is_mode;
  wire       stat_rd  = ~rd_n & is_mode;
  wire       term     = cnt_q[act_ch][CW-1:0] == '0;
  wire       reload   = byte_done & term & auto_q & (act_ch == 2'd2);

  assign tc_out   = byte_done & term;
  assign mark_out = byte_done & (tally_q[act_ch] == {TW{1'b1}});
  assign cur_addr = addr_q[act_ch];
  assign cur_op   = cnt_q[act_ch][15:14];
  assign ch_en    = en_q;
  assign auto_ld  = auto_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NCH; i++) begin
        addr_q[i]  <= '0;
        cnt_q[i]   <= '0;
        tally_q[i] <= '0;
      end
    end else begin
      for (int i = 0; i < NCH; i++) begin
        if (byte_done && act_ch == 2'(i)) begin
          if (reload && i == 2) begin
            addr_q[i]  <= addr_q[3];
            cnt_q[i]   <= cnt_q[3];
            tally_q[i] <= '0;
          end else begin
            addr_q[i]  <= addr_q[i] + 16'd1;
            cnt_q[i]   <= {cnt_q[i][15:14], cnt_q[i][CW-1:0] - CW'(1)};
            tally_q[i] <= tally_q[i] + TW'(1);
          end
        end
        if (wr_ch && sel == 2'(i)) begin
          if (!reg_addr[0]) begin
            addr_q[i] <= ff_q ? {din, addr_q[i][7:0]} : {addr_q[i][15:8], din};
          end else begin
            cnt_q[i]   <= ff_q ? {din, cnt_q[i][7:0]} : {cnt_q[i][15:8], din};
            tally_q[i] <= '0;
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ff_q   <= 1'b0;
      en_q   <= '0;
      auto_q <= 1'b0;
      tc_q   <= '0;
      upd_q  <= 1'b0;
    end else begin
      if (mode_wr) ff_q <= 1'b0;
      else if (wr_ch || rd_ch) ff_q <= ~ff_q;
      if (mode_wr) begin
        en_q   <= din[3:0];
        auto_q <= din[7];
      end
      tc_q <= (tc_q & {4{~stat_rd}}) | ({3'b0, tc_out} << act_ch);
      if (reload) upd_q <= 1'b1;
      else if (mode_wr || (byte_done && act_ch == 2'd2)) upd_q <= 1'b0;
    end
  end

  always_comb begin
    dout = '0;
    if (!rd_n) begin
      if (is_ch) begin
        if (!reg_addr[0]) dout = ff_q ? addr_q[sel][15:8] : addr_q[sel][7:0];
        else              dout = ff_q ? cnt_q[sel][15:8]  : cnt_q[sel][7:0];
      end else if (is_mode) begin
        dout = {3'b0, upd_q, tc_q};
      end
    end
  end
endmodule

// File: rtl/dma_chan_regs_chk.sv
module dma_chan_regs_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [3:0] reg_addr,
  input logic       wr_n,
  input logic       rd_n,
  input logic [7:0] dout,
  input logic       byte_done,
  input logic [1:0] act_ch,
  input logic       tc_out,
  input logic       mark_out,
  input logic [3:0] tc_q,
  input logic       upd_q,
  input logic       ff_q
);
  assert_tc_sets_status_R5: assert property (@(posedge clk) disable iff (!rst_n)
    tc_out |=> tc_q[$past(act_ch)]);

  assert_pulse_needs_byte_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (tc_out || mark_out) |-> byte_done);

  assert_upd_survives_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_q && !rd_n && reg_addr == 4'd8 && wr_n && !byte_done) |=> upd_q);

  assert_mode_rewinds_ptr_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_n && reg_addr == 4'd8) |=> !ff_q);

  assert_idle_bus_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_n |-> dout == 8'h00);

  assert_hole_keeps_ptr_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr[3] && !(reg_addr == 4'd8 && !wr_n)) |=> ff_q == $past(ff_q));

  assert_status_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_n && reg_addr == 4'd8 && !tc_out) |=> tc_q == 4'h0);
endmodule

bind dma_chan_regs dma_chan_regs_chk u_chk (
  .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .wr_n(wr_n), .rd_n(rd_n),
  .dout(dout), .byte_done(byte_done), .act_ch(act_ch), .tc_out(tc_out),
  .mark_out(mark_out), .tc_q(tc_q), .upd_q(upd_q), .ff_q(ff_q)
);

// File: tb/dma_chan_regs_bench.sv
`timescale 1ns/1ps
module dma_chan_regs_bench;
  logic        clk = 0, rst_n = 0;
  logic [3:0]  reg_addr = 0;
  logic        wr_n = 1, rd_n = 1, byte_done = 0;
  logic [7:0]  din = 0;
  logic [1:0]  act_ch = 0;
  logic [7:0]  dout;
  logic [15:0] cur_addr;
  logic [1:0]  cur_op;
  logic [3:0]  ch_en;
  logic        auto_ld, tc_out, mark_out;
  int tests = 0, fails = 0;

  always #2.5 clk = ~clk;

  dma_chan_regs u_dma_chan_regs (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .wr_n(wr_n), .rd_n(rd_n),
    .din(din), .dout(dout), .byte_done(byte_done), .act_ch(act_ch),
    .cur_addr(cur_addr), .cur_op(cur_op), .ch_en(ch_en), .auto_ld(auto_ld),
    .tc_out(tc_out), .mark_out(mark_out)
  );

  // {read, code, write data, expected read data}
  localparam int NV = 20;
  localparam logic [20:0] VEC [NV] = '{
    {1'b0, 4'd8, 8'h0F, 8'h00},  // R2 mode
    {1'b0, 4'd0, 8'h34, 8'h00},  // R1 ch0 address
    {1'b0, 4'd0, 8'h12, 8'h00},
    {1'b0, 4'd1, 8'h02, 8'h00},  // R1 ch0 count, read type
    {1'b0, 4'd1, 8'h80, 8'h00},
    {1'b0, 4'd6, 8'hCD, 8'h00},
    {1'b0, 4'd6, 8'hAB, 8'h00},
    {1'b1, 4'd0, 8'h00, 8'h34},
    {1'b1, 4'd0, 8'h00, 8'h12},
    {1'b1, 4'd1, 8'h00, 8'h02},
    {1'b1, 4'd1, 8'h00, 8'h80},
    {1'b0, 4'd9, 8'h55, 8'h00},  // R3 hole write
    {1'b1, 4'd6, 8'h00, 8'hCD},
    {1'b1, 4'd6, 8'h00, 8'hAB},
    {1'b1, 4'd9, 8'h00, 8'h00},  // R3 hole read
    {1'b1, 4'd8, 8'h00, 8'h00},
    {1'b0, 4'd0, 8'h78, 8'h00},  // low byte only
    {1'b0, 4'd8, 8'h0F, 8'h00},  // R2 pointer rewind
    {1'b1, 4'd0, 8'h00, 8'h78},
    {1'b1, 4'd0, 8'h00, 8'h12}
  };

  task automatic check(string req, logic [31:0] got, logic [31:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [7:0] d);
    @(negedge clk); reg_addr = a; din = d; wr_n = 0;
    @(negedge clk); wr_n = 1;
  endtask

  task automatic rd(logic [3:0] a, output logic [7:0] v);
    @(negedge clk); reg_addr = a; rd_n = 0; #1 v = dout;
    @(negedge clk); rd_n = 1;
  endtask

  task automatic step(logic [1:0] c, output logic t, output logic m);
    @(negedge clk); act_ch = c; byte_done = 1; #1 t = tc_out; m = mark_out;
    @(negedge clk); byte_done = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [7:0] v;
    logic t, m;
    int marks, first;
    repeat (3) @(negedge clk);
    check("R11 dout idle", dout, 0);
    check("R11 cur_addr", cur_addr, 0);
    check("R11 ch_en", {auto_ld, ch_en}, 0);
    rst_n = 1;
    rd(4'd8, v); check("R11 status", v, 0);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][20]) begin
        rd(VEC[i][19:16], v);
        check($sformatf("R1/R3 vector %0d", i), v, VEC[i][7:0]);
      end else begin
        wr(VEC[i][19:16], VEC[i][15:8]);
      end
    end
    check("R2 enables", {auto_ld, ch_en}, 5'h0F);

    act_ch = 0; #1;
    check("R4 cur_addr", cur_addr, 16'h1278);
    check("R4 cur_op", cur_op, 2'b10);
    step(0, t, m); check("R5 not last", t, 0);
    check("R4 address stepped", cur_addr, 16'h1279);
    step(0, t, m); check("R5 not last", t, 0);
    step(0, t, m); check("R5 last byte", t, 1);
    check("R4 address after 3", cur_addr, 16'h127B);
    rd(4'd8, v); check("R5 status TC0", v, 8'h01);
    rd(4'd8, v); check("R6 cleared on read", v, 8'h00);
    wr(4'd8, 8'h0F);
    rd(4'd1, v); check("R4 count wrap low", v, 8'hFF);
    rd(4'd1, v); check("R4 count wrap high keeps type", v, 8'hBF);

    wr(4'd3, 8'hFF); wr(4'd3, 8'h4F);
    marks = 0; first = -1;
    for (int i = 0; i < 256; i++) begin
      step(1, t, m);
      if (m) begin marks++; if (first < 0) first = i; end
    end
    check("R7 first mark at byte 128", first, 127);
    check("R7 marks in 256 bytes", marks, 2);

    wr(4'd7, 8'h01); wr(4'd7, 8'h40);
    wr(4'd4, 8'h00); wr(4'd4, 8'h20);
    wr(4'd5, 8'h00); wr(4'd5, 8'h00);
    wr(4'd8, 8'h8F);
    check("R2 auto_ld", auto_ld, 1);
    step(2, t, m); check("R8 terminal on ch2", t, 1);
    act_ch = 2; #1;
    check("R8 address reloaded", cur_addr, 16'hABCD);
    check("R8 type reloaded", cur_op, 2'b01);
    rd(4'd8, v); check("R8 status TC2 and update", v, 8'h14);
    rd(4'd8, v); check("R9 update survives read", v, 8'h10);
    step(2, t, m); check("R8 reloaded count not last", t, 0);
    rd(4'd8, v); check("R9 update cleared by byte", v, 8'h00);
    check("R4 reloaded address steps", cur_addr, 16'hABCE);

    wr(4'd8, 8'h0F);
    wr(4'd5, 8'h00); wr(4'd5, 8'h00);
    step(2, t, m); check("R5 terminal no reload", t, 1);
    check("R8 no reload when disarmed", cur_addr, 16'hABCF);
    rd(4'd8, v); check("R8 no update flag", v, 8'h04);
    wr(4'd8, 8'h8F);
    wr(4'd5, 8'h00); wr(4'd5, 8'h00);
    step(2, t, m);
    wr(4'd8, 8'h0F);
    rd(4'd8, v); check("R9 mode write clears update", v, 8'h04);

    wr(4'd8, 8'h0F);
    wr(4'd1, 8'h00); wr(4'd1, 8'h00);
    @(negedge clk); reg_addr = 4'd8; rd_n = 0; act_ch = 0; byte_done = 1;
    #1 v = dout; t = tc_out;
    @(negedge clk); rd_n = 1; byte_done = 0;
    check("R6 read returns old status", v, 8'h00);
    check("R5 clash terminal", t, 1);
    rd(4'd8, v); check("R6 set wins over clear", v, 8'h01);

    wr(4'd8, 8'h0F);
    @(negedge clk); reg_addr = 4'd0; din = 8'h10; wr_n = 0; act_ch = 0; byte_done = 1;
    @(negedge clk); wr_n = 1; byte_done = 0;
    check("R10 write beats step", cur_addr[7:0], 8'h10);
    wr(4'd8, 8'h0F);
    rd(4'd1, v); check("R10 count still steps low", v, 8'hFE);
    rd(4'd1, v); check("R10 count still steps high", v, 8'h3F);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule